// File: doc/BRIEF.md
# UART Transmit Engine

This block is the transmit half of an asynchronous serial port. Bytes arrive on a valid/ready stream and are stored in a 16-entry queue. A divisor-driven tick generator paces a frame serializer, which drives the serial output. Word length, parity mode, stop-bit count, line break and the 16-bit baud divisor are static configuration pins. The serializer samples them when each frame is loaded, so they must only change while the engine is idle.

The tick generator is a down counter clocked by the core clock. When it reaches zero, it reloads the divisor and produces a one-cycle 16x oversampling tick. The serializer counts sixteen ticks per bit. When the queue holds data, a frame begins. Frames follow one another with no idle gap until the queue is empty. The `busy` output stays high from the first accepted byte until the queue is empty and the final stop bit has been sent. It does not depend on `enable`.

Stream rules: a byte transfers on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is the inverse of `fifo_full`. A byte offered while the queue is full is not taken. The producer may hold it until `in_ready` returns, or withdraw it, in which case it is lost.

Top module: `uart_tx_engine`

## Requirements
- R1: One bit on `txd` lasts exactly 16*(cfg_divisor+1) clock cycles. The tick generator reloads from `cfg_divisor`, so its tick period is cfg_divisor+1 cycles. The divider restarts each time a frame leaves the idle state.
- R2: A frame begins with one low start bit. It is followed by the data bits, least significant bit first. The number of data bits is 5 plus `cfg_word_len` (code 0 gives 5 bits, code 3 gives 8 bits). Only the low bits of the byte are sent.
- R3: `cfg_parity` selects the parity bit that follows the data: 0 none, 1 even (total ones in data plus parity is even), 2 odd, 3 constant 1, 4 constant 0. Codes 5 to 7 act as none.
- R4: After the data and any parity bit, the line is held high for one stop bit when `cfg_two_stop` is 0 and for two when it is 1.
- R5: While the queue is non-empty, the next frame's start bit begins on the same edge that ends the previous frame's last stop bit. There is no idle cycle between frames.
- R6: The queue holds 16 bytes. `fifo_full` is high and `in_ready` is low while 16 bytes are stored. A byte offered then is not stored and never appears on the line.
- R7: `busy` is high from the cycle after a byte is accepted. It falls on the same edge that ends the last stop bit of the last queued byte. At that edge `txd` returns high.
- R8: While `enable` is low, no frame starts, an active frame holds its position, and bytes are still accepted. `busy` stays high whenever data is queued or a frame is active.
- R9: While `cfg_break` is high, `txd` is low, whatever the frame state.
- R10: After reset, `txd` is high, `busy` and `fifo_full` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the baud reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows frames to start and progress |
| cfg_divisor | input | 16 | Baud divisor; tick period is value+1 cycles |
| cfg_word_len | input | 2 | Data bits minus 5 |
| cfg_parity | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_break | input | 1 | Forces the line low |
| in_valid | input | 1 | Byte offered on in_data |
| in_data | input | 8 | Byte to transmit |
| in_ready | output | 1 | Queue can accept a byte |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | Data queued or frame in flight |
| fifo_full | output | 1 | Queue holds 16 bytes |

## Verification
The bench sweeps every word length, parity code and stop count at two divisors. It samples each bit in its first and last cycle. A bit period off by one cycle, bits sent in the wrong order, or an inverted or misplaced parity bit all show up as a wrong value at one of those samples. A sixteen-byte queue is filled with the engine disabled, and a seventeenth byte is then offered. If the design stores that byte or wraps the queue, it sends an extra or corrupted frame, and `busy` does not fall on the predicted edge. The queued frames are then sent back to back. A design that inserts an idle gap between frames, or lowers `busy` early, is caught at the frame boundaries and at the final stop-bit edge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } parity_e;

  localparam int FRAME_MAX = 12;
  localparam int LEN_W     = 4;

  typedef struct packed {
    logic [FRAME_MAX-1:0] bits;
    logic [LEN_W-1:0]     len;
  } frame_t;

  // Assemble a full frame, bit 0 first on the line: start, data, parity, stops.
  function automatic frame_t build_frame(input logic [7:0] data,
                                         input logic [1:0] word_len,
                                         input logic [2:0] parity,
                                         input logic       two_stop);
    frame_t     f;
    int         w;
    int         n;
    logic [7:0] d;
    logic       p;
    logic       par_en;
    w = 5 + int'(word_len);
    d = data & 8'((1 << w) - 1);
    par_en = 1'b1;
    case (parity)
      PAR_EVEN:  p = ^d;
      PAR_ODD:   p = ~^d;
      PAR_MARK:  p = 1'b1;
      PAR_SPACE: p = 1'b0;
      default: begin
        p = 1'b1;
        par_en = 1'b0;
      end
    endcase
    f.bits = (12'hFFF << (w + 1)) | {3'b000, d, 1'b0};
    if (par_en && !p) f.bits = f.bits & ~(12'd1 << (w + 1));
    n = 1 + w + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
    f.len = LEN_W'(n);
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign push_ready = !full;
  assign do_push    = push_valid && !full;
  assign do_pop     = pop && !empty;
  assign pop_data   = mem[rd_ptr];

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= advance(wr_ptr);
      if (do_pop)  rd_ptr <= advance(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // A byte offered to a full queue must leave the occupancy untouched.
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !pop) |=> (full && $stable(count)));

  // The serializer only pops when a byte is waiting.
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = enable && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= divisor;
    end else if (enable) begin
      cnt <= (cnt == '0) ? divisor : cnt - 1'b1;
    end
  end

  // With a non-zero divisor two ticks never land on adjacent cycles.
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor != '0) |=> !tick);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  input  logic [1:0] cfg_word_len,
  input  logic [2:0] cfg_parity,
  input  logic       cfg_two_stop,
  output logic       pop,
  output logic       restart,
  output logic       active,
  output logic       line
);
  localparam int SW = $clog2(OVERSAMPLE);

  logic [FRAME_MAX-1:0] frame_q;
  logic [LEN_W-1:0]     left_q;
  logic [SW-1:0]        sub_q;
  logic                 active_q;
  frame_t               next_frame;
  logic                 start_idle, bit_end, frame_end;

  always_comb next_frame = build_frame(fifo_data, cfg_word_len, cfg_parity, cfg_two_stop);

  assign start_idle = !active_q && enable && !fifo_empty;
  assign bit_end    = active_q && tick && (sub_q == SW'(OVERSAMPLE - 1));
  assign frame_end  = bit_end && (left_q == LEN_W'(1));
  assign pop        = start_idle || (frame_end && !fifo_empty);
  assign restart    = !active_q;
  assign active     = active_q;
  assign line       = active_q ? frame_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      frame_q  <= '1;
      left_q   <= '0;
      sub_q    <= '0;
    end else if (pop) begin
      active_q <= 1'b1;
      frame_q  <= next_frame.bits;
      left_q   <= next_frame.len;
      sub_q    <= '0;
    end else if (frame_end) begin
      active_q <= 1'b0;
      frame_q  <= '1;
      sub_q    <= '0;
    end else if (bit_end) begin
      frame_q  <= {1'b1, frame_q[FRAME_MAX-1:1]};
      left_q   <= left_q - 1'b1;
      sub_q    <= '0;
    end else if (active_q && tick) begin
      sub_q    <= sub_q + 1'b1;
    end
  end

  // Every frame opens with a low start bit.
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> !line);

  // The shifter only goes idle at the close of a bit period.
  assert_frame_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(tick && sub_q == SW'(OVERSAMPLE - 1)));

  // With enable low, the frame position is frozen.
  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && active_q) |=> (active_q && $stable(frame_q) && $stable(sub_q)));

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic [1:0]       cfg_word_len,
  input  logic [2:0]       cfg_parity,
  input  logic             cfg_two_stop,
  input  logic             cfg_break,
  input  logic             in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic             in_ready,
  output logic             txd,
  output logic             busy,
  output logic             fifo_full
);
  logic              fifo_empty, pop, tick, restart, active, line;
  logic [DATA_W-1:0] head;

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (in_valid),
    .push_data  (in_data),
    .push_ready (in_ready),
    .pop        (pop),
    .pop_data   (head),
    .empty      (fifo_empty),
    .full       (fifo_full)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .restart (restart),
    .divisor (cfg_divisor),
    .tick    (tick)
  );

  uart_tx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .tick         (tick),
    .fifo_empty   (fifo_empty),
    .fifo_data    (head[7:0]),
    .cfg_word_len (cfg_word_len),
    .cfg_parity   (cfg_parity),
    .cfg_two_stop (cfg_two_stop),
    .pop          (pop),
    .restart      (restart),
    .active       (active),
    .line         (line)
  );

  assign busy = !fifo_empty || active;
  assign txd  = cfg_break ? 1'b0 : line;

  // An idle engine leaves the line marking unless break forces it low.
  assert_idle_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd || cfg_break));

  // Busy survives a deasserted enable.
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && busy) |=> busy);

  // A full queue can never coexist with an idle engine.
  assert_full_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> busy);

endmodule

// File: tb/uart_tx_engine_bench.sv
`timescale 1ns/1ps
module uart_tx_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic [15:0] cfg_divisor = 16'd0;
  logic [1:0]  cfg_word_len = 2'd3;
  logic [2:0]  cfg_parity = 3'd0;
  logic        cfg_two_stop = 1'b0;
  logic        cfg_break = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready, txd, busy, fifo_full;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  uart_tx_engine u_uart_tx_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_divisor(cfg_divisor),
    .cfg_word_len(cfg_word_len), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_break(cfg_break), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .txd(txd), .busy(busy),
    .fifo_full(fifo_full)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, actual, expected);
    end
  endtask

  function automatic int frame_len(input int wl, input int pr, input int ts);
    return 1 + 5 + wl + ((pr >= 1 && pr <= 4) ? 1 : 0) + (ts != 0 ? 2 : 1);
  endfunction

  function automatic logic exp_bit(input int i, input logic [7:0] d,
                                   input int wl, input int pr);
    int   w;
    logic p;
    w = 5 + wl;
    if (i == 0) return 1'b0;
    if (i <= w) return d[i-1];
    if (i == w + 1 && pr >= 1 && pr <= 4) begin
      p = 1'b0;
      for (int k = 0; k < w; k++) p ^= d[k];
      case (pr)
        1: return p;
        2: return ~p;
        3: return 1'b1;
        default: return 1'b0;
      endcase
    end
    return 1'b1;
  endfunction

  function automatic string bit_req(input int i, input int wl, input int pr);
    if (i <= 5 + wl) return "R2";
    if (i == 6 + wl && pr >= 1 && pr <= 4) return "R3";
    return "R4";
  endfunction

  // Offer one byte for one cycle; returns just after the transfer edge.
  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // Entry: just after the edge that started the frame.
  task automatic run_frame(input logic [7:0] d, input bit last);
    int n;
    int per;
    n   = frame_len(int'(cfg_word_len), int'(cfg_parity), int'(cfg_two_stop));
    per = 16 * (int'(cfg_divisor) + 1);
    for (int i = 0; i < n; i++) begin
      chk(bit_req(i, int'(cfg_word_len), int'(cfg_parity)), txd,
          exp_bit(i, d, int'(cfg_word_len), int'(cfg_parity)));
      repeat (per - 1) @(posedge clk);
      #1;
      chk("R1", txd, exp_bit(i, d, int'(cfg_word_len), int'(cfg_parity)));
      chk("R7", busy, 1'b1);
      @(posedge clk);
      #1;
    end
    if (last) begin
      chk("R7", busy, 1'b0);
      chk("R7", txd, 1'b1);
    end else begin
      chk("R5", busy, 1'b1);
    end
  endtask

  initial begin
    logic [7:0] q [16];
    int idx;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", txd, 1'b1);
    chk("R10", busy, 1'b0);
    chk("R10", fifo_full, 1'b0);
    chk("R10", in_ready, 1'b1);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // Sweep of all framing options at two divisors.
    idx = 0;
    for (int dv = 0; dv < 2; dv++)
      for (int wl = 0; wl < 4; wl++)
        for (int pr = 0; pr < 5; pr++)
          for (int ts = 0; ts < 2; ts++) begin
            logic [7:0] d;
            d = 8'((idx * 37 + 91) ^ (idx << 3));
            idx++;
            cfg_divisor  = 16'(dv);
            cfg_word_len = 2'(wl);
            cfg_parity   = 3'(pr);
            cfg_two_stop = 1'(ts);
            send_byte(d);
            chk("R7", busy, 1'b1);
            @(posedge clk);
            #1;
            run_frame(d, 1'b1);
          end

    // Longer divisor, unused parity code.
    cfg_divisor = 16'd3; cfg_word_len = 2'd3; cfg_parity = 3'd6; cfg_two_stop = 1'b0;
    send_byte(8'hA5);
    @(posedge clk);
    #1;
    run_frame(8'hA5, 1'b1);

    // Fill the queue while disabled, then drain back to back.
    cfg_divisor = 16'd0; cfg_word_len = 2'd2; cfg_parity = 3'd2; cfg_two_stop = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    for (int k = 0; k < 16; k++) begin
      q[k] = 8'(k * 29 + 5);
      chk("R6", in_ready, 1'b1);
      send_byte(q[k]);
    end
    chk("R6", fifo_full, 1'b1);
    chk("R6", in_ready, 1'b0);
    send_byte(8'hFF);
    chk("R6", fifo_full, 1'b1);
    repeat (40) @(posedge clk);
    #1;
    chk("R8", busy, 1'b1);
    chk("R8", txd, 1'b1);
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
    #1;
    chk("R6", fifo_full, 1'b0);
    for (int k = 0; k < 16; k++) run_frame(q[k], k == 15);

    // Break overrides the idle line.
    @(negedge clk);
    cfg_break = 1'b1;
    #1;
    chk("R9", txd, 1'b0);
    repeat (5) @(posedge clk);
    #1;
    chk("R9", txd, 1'b0);
    chk("R9", busy, 1'b0);
    @(negedge clk);
    cfg_break = 1'b0;
    #1;
    chk("R9", txd, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule